// File: doc/BRIEF.md
# Converter Register Block with Synthetic Sampler

This block is the software-visible face of a single analog-to-digital converter. A 32-bit word-addressed bus reads and writes a bank of control, timing, threshold, sequence and injected-channel registers. A counter-based sample source stands in for the analog front end. Each qualifying read of the regular-data register produces a new conversion result. No clock-driven conversion takes place.

A conversion happens only when two bits in the second control register are both set: the converter-enable bit and the one-shot software-start bit. The read consumes the start bit. The sample source adds a fixed step to its stored value and truncates the sum to the selected resolution. The read then returns that value, either right-aligned or shifted left and masked. Injected-channel reads return stored data minus a per-channel 12-bit offset. The status register can only lose bits. The interrupt output is tied low.

Decoding follows a fixed path. The byte address becomes a register selector. A read registers its selected word into `rdata` on the clock edge of the strobe. A write updates the selected register on the same edge. A conversion-triggering read also advances the sample source on that edge and clears the start bit.

Top module: `adc_regblk`

## Requirements
- R1: After reset every register reads 0, except the high-threshold register at 0x24, which reads 0x00000FFF.
- R2: A write to status (0x00) sets it to its old value ANDed with wdata[5:0], so a write can never set a status bit.
- R3: A read of regular data (0x4C) with CR2 bit 0 (enable) and CR2 bit 30 (start) both set clears bit 30 and returns a new sample. In every other case the read returns 0 and leaves the stored sample unchanged.
- R4: Each new sample is the previous stored sample plus 7, truncated to the selected resolution and stored back.
- R5: CR1 (0x04) bits 25:24 select the resolution: 0 gives 12 bits (0xFFF), 1 gives 10 bits (0x3FF), 2 gives 8 bits (0xFF) and 3 gives 6 bits (0x3F).
- R6: With CR2 bit 11 set, the returned sample is the stored sample shifted left by one and ANDed with 0xFFF0. With bit 11 clear, it is returned unchanged.
- R7: A read of CR2 (0x08) returns bits 27:0 as written and 0 in bits 31:28.
- R8: The four injected offsets (0x14, 0x18, 0x1C, 0x20) keep only wdata[11:0].
- R9: A read of injected data n (0x3C + 4n) returns stored data n minus offset n, modulo 2^32.
- R10: Unmapped, misaligned and common-area (0x100 and above) addresses read 0 and ignore writes. Writes to 0x4C have no effect.
- R11: rdata holds the result one clock after the read strobe. Two back-to-back regular-data reads give a sample and then 0.
- R12: irq is held at 0.
- R13: CR1, the two sample-time registers (0x0C, 0x10), the thresholds (0x24, 0x28), the three sequence registers (0x2C, 0x30, 0x34) and the injected sequence (0x38) read back the full 32-bit word last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (12) | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
The bench drives the sample source through the 0xFFF wrap at 12 bits and through every other resolution. A design that masked before adding, or that kept the old mask, would produce values drifting off the modelled sequence. The bench also reads regular data with the enable bit clear, reads it twice back-to-back, and writes to 0x4C. A design that consumed the start bit late, or that let such accesses advance or overwrite the sample, would return a nonzero second read or a shifted sequence. An injected offset larger than its data exposes a subtraction that saturates or loses the borrow. Writes to the common area catch address aliasing onto CR1.

// File: rtl/adc_regblk_pkg.sv
package adc_regblk_pkg;

    localparam int unsigned INJ_N   = 4;
    localparam int unsigned OFS_W   = 12;
    localparam int unsigned STEP    = 7;
    localparam int unsigned OFS_CR2 = 'h08;
    localparam int unsigned OFS_DR  = 'h4C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SR, SEL_CR1, SEL_CR2, SEL_SMP1, SEL_SMP2,
        SEL_JOFS, SEL_HTH, SEL_LTH, SEL_SEQ1, SEL_SEQ2, SEL_SEQ3,
        SEL_JSEQ, SEL_JDAT, SEL_DR
    } reg_sel_e;

    function automatic logic [31:0] res_mask(input logic [1:0] res);
        unique case (res)
            2'd0:    return 32'h0000_0FFF;
            2'd1:    return 32'h0000_03FF;
            2'd2:    return 32'h0000_00FF;
            default: return 32'h0000_003F;
        endcase
    endfunction

endpackage

// File: rtl/adc_addr_dec.sv
module adc_addr_dec
    import adc_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]        addr,
    output reg_sel_e                 sel,
    output logic [$clog2(INJ_N)-1:0] slot
);
    localparam int unsigned SLOT_W = $clog2(INJ_N);

    int unsigned widx;

    always_comb begin
        widx = int'(addr[ADDR_W-1:2]);
        sel  = SEL_NONE;
        slot = '0;
        if (addr[1:0] == 2'b00) begin
            if (widx == 0)                          sel = SEL_SR;
            else if (widx == 1)                     sel = SEL_CR1;
            else if (widx == 2)                     sel = SEL_CR2;
            else if (widx == 3)                     sel = SEL_SMP1;
            else if (widx == 4)                     sel = SEL_SMP2;
            else if (widx >= 5 && widx < 5 + INJ_N) begin
                sel  = SEL_JOFS;
                slot = SLOT_W'(widx - 5);
            end
            else if (widx == 9)                     sel = SEL_HTH;
            else if (widx == 10)                    sel = SEL_LTH;
            else if (widx == 11)                    sel = SEL_SEQ1;
            else if (widx == 12)                    sel = SEL_SEQ2;
            else if (widx == 13)                    sel = SEL_SEQ3;
            else if (widx == 14)                    sel = SEL_JSEQ;
            else if (widx >= 15 && widx < 15 + INJ_N) begin
                sel  = SEL_JDAT;
                slot = SLOT_W'(widx - 15);
            end
            else if (widx == OFS_DR / 4)            sel = SEL_DR;
        end
    end
endmodule

// File: rtl/adc_inj_bank.sv
module adc_inj_bank
    import adc_regblk_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ofs_we,
    input  logic                     dat_we,
    input  logic [$clog2(INJ_N)-1:0] slot,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rd_ofs,
    output logic [DW-1:0]            rd_diff
);
    logic [OFS_W-1:0] ofs_arr [INJ_N];
    logic [DW-1:0]    dat_arr [INJ_N];

    for (genvar i = 0; i < INJ_N; i++) begin : g_slot
        logic [OFS_W-1:0] ofs_r;
        logic [DW-1:0]    dat_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ofs_r <= '0;
                dat_r <= '0;
            end else begin
                if (ofs_we && slot == i) ofs_r <= wdata[OFS_W-1:0];
                if (dat_we && slot == i) dat_r <= wdata;
            end
        end
        assign ofs_arr[i] = ofs_r;
        assign dat_arr[i] = dat_r;
    end

    assign rd_ofs  = DW'(ofs_arr[slot]);
    assign rd_diff = dat_arr[slot] - DW'(ofs_arr[slot]);
endmodule

// File: rtl/adc_sampler.sv
module adc_sampler
    import adc_regblk_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [1:0]    res,
    input  logic          align,
    output logic [DW-1:0] ret
);
    logic [DW-1:0] smp_q;
    logic [DW-1:0] smp_nx;

    assign smp_nx = (smp_q + DW'(STEP)) & DW'(res_mask(res));
    assign ret    = align ? ({smp_nx[DW-2:0], 1'b0} & DW'(32'h0000_FFF0)) : smp_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    smp_q <= '0;
        else if (fire) smp_q <= smp_nx;
    end
endmodule

// File: rtl/adc_regblk.sv
module adc_regblk
    import adc_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ST_W    = 6,
    parameter int unsigned HTH_RST = 'hFFF,
    parameter int unsigned EN_BIT  = 0,
    parameter int unsigned AL_BIT  = 11,
    parameter int unsigned SW_BIT  = 30,
    parameter int unsigned RES_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int unsigned SLOT_W = $clog2(INJ_N);
    localparam int unsigned CR2_VW = 28;

    reg_sel_e            sel;
    logic [SLOT_W-1:0]   slot;
    logic [ST_W-1:0]     sr_q;
    logic [DATA_W-1:0]   cr1_q, cr2_q, smp1_q, smp2_q, hth_q, lth_q;
    logic [DATA_W-1:0]   seq1_q, seq2_q, seq3_q, jseq_q;
    logic [DATA_W-1:0]   jofs_rd, jdat_rd, gen_ret, rd_mux;
    logic                fire;

    adc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .slot (slot)
    );

    assign fire = rd_en && (sel == SEL_DR) && cr2_q[EN_BIT] && cr2_q[SW_BIT];

    adc_sampler #(.DW(DATA_W)) u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .res   (cr1_q[RES_LSB+1:RES_LSB]),
        .align (cr2_q[AL_BIT]),
        .ret   (gen_ret)
    );

    adc_inj_bank #(.DW(DATA_W)) u_inj (
        .clk     (clk),
        .rst_n   (rst_n),
        .ofs_we  (wr_en && sel == SEL_JOFS),
        .dat_we  (wr_en && sel == SEL_JDAT),
        .slot    (slot),
        .wdata   (wdata),
        .rd_ofs  (jofs_rd),
        .rd_diff (jdat_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cr1_q  <= '0;
            cr2_q  <= '0;
            smp1_q <= '0;
            smp2_q <= '0;
            hth_q  <= DATA_W'(HTH_RST);
            lth_q  <= '0;
            seq1_q <= '0;
            seq2_q <= '0;
            seq3_q <= '0;
            jseq_q <= '0;
        end else begin
            if (fire) cr2_q[SW_BIT] <= 1'b0;
            if (wr_en) begin
                unique case (sel)
                    SEL_SR:   sr_q   <= sr_q & wdata[ST_W-1:0];
                    SEL_CR1:  cr1_q  <= wdata;
                    SEL_CR2:  cr2_q  <= wdata;
                    SEL_SMP1: smp1_q <= wdata;
                    SEL_SMP2: smp2_q <= wdata;
                    SEL_HTH:  hth_q  <= wdata;
                    SEL_LTH:  lth_q  <= wdata;
                    SEL_SEQ1: seq1_q <= wdata;
                    SEL_SEQ2: seq2_q <= wdata;
                    SEL_SEQ3: seq3_q <= wdata;
                    SEL_JSEQ: jseq_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SR:   rd_mux = DATA_W'(sr_q);
            SEL_CR1:  rd_mux = cr1_q;
            SEL_CR2:  rd_mux = DATA_W'(cr2_q[CR2_VW-1:0]);
            SEL_SMP1: rd_mux = smp1_q;
            SEL_SMP2: rd_mux = smp2_q;
            SEL_JOFS: rd_mux = jofs_rd;
            SEL_HTH:  rd_mux = hth_q;
            SEL_LTH:  rd_mux = lth_q;
            SEL_SEQ1: rd_mux = seq1_q;
            SEL_SEQ2: rd_mux = seq2_q;
            SEL_SEQ3: rd_mux = seq3_q;
            SEL_JSEQ: rd_mux = jseq_q;
            SEL_JDAT: rd_mux = jdat_rd;
            SEL_DR:   rd_mux = fire ? gen_ret : '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = 1'b0;
endmodule

// File: rtl/adc_regblk_chk.sv
module adc_regblk_chk
    import adc_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [1:0]        res,
    input logic              adon,
    input logic              align,
    input logic              swst,
    input logic [5:0]        sr
);
    logic rd_dr, rd_cr2;
    assign rd_dr  = rd_en && (addr == ADDR_W'(OFS_DR));
    assign rd_cr2 = rd_en && (addr == ADDR_W'(OFS_CR2));

    p_status_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr & ~$past(sr)) == 6'd0);

    p_idle_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dr && !(adon && swst)) |=> rdata == 32'd0);

    p_start_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dr && adon && swst && !wr_en) |=> !swst);

    p_res_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dr && adon && swst && !align) |=> (rdata & ~res_mask($past(res))) == 32'd0);

    p_align_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dr && adon && swst && align) |=> (rdata[3:0] == 4'd0 && rdata[31:16] == 16'd0));

    p_cr2_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cr2 |=> rdata[31:28] == 4'd0);
endmodule

bind adc_regblk adc_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .rdata (rdata),
    .res   (cr1_q[25:24]),
    .adon  (cr2_q[0]),
    .align (cr2_q[11]),
    .swst  (cr2_q[30]),
    .sr    (sr_q)
);

// File: tb/adc_regblk_tb.sv
module adc_regblk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    int unsigned model_smp = 0;
    logic [1:0]  cur_res = 2'd0;

    always #10 clk = ~clk;

    adc_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int unsigned mask_of(input logic [1:0] r);
        case (r)
            2'd0: return 'hFFF;
            2'd1: return 'h3FF;
            2'd2: return 'hFF;
            default: return 'h3F;
        endcase
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a == 12'h004) cur_res = d[25:24];
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic sample(input logic al, input string t);
        int unsigned e;
        wr(12'h008, 32'h4000_0001 | (32'(al) << 11));
        model_smp = (model_smp + 7) & mask_of(cur_res);
        e = al ? ((model_smp << 1) & 'hFFF0) : model_smp;
        rd(12'h04C, e, t);
    endtask

    // monitor: scoreboard compare one clock after each read strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected read actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, addr, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: interrupt low
        compared++;
        if (irq !== 1'b0) begin
            mismatched++;
            $display("FAIL R12 actual=%b expected=0", irq);
        end

        // R1: reset values
        rd(12'h000, 32'h0, "R1");
        rd(12'h004, 32'h0, "R1");
        rd(12'h008, 32'h0, "R1");
        rd(12'h024, 32'h0000_0FFF, "R1");
        rd(12'h028, 32'h0, "R1");
        rd(12'h040, 32'h0, "R1");
        rd(12'h04C, 32'h0, "R1");

        // R3: start bit without enable gives 0 and no advance
        wr(12'h008, 32'h4000_0000);
        rd(12'h04C, 32'h0, "R3");
        rd(12'h008, 32'h0, "R7");

        // R4/R7: first sample, start consumed, masked CR2 read
        wr(12'h008, 32'h4000_0001);
        rd(12'h008, 32'h0000_0001, "R7");
        model_smp = 7;
        rd(12'h04C, 32'd7, "R4");
        rd(12'h04C, 32'h0, "R3");
        rd(12'h008, 32'h0000_0001, "R3");

        // R11: back-to-back reads give sample then 0
        wr(12'h008, 32'h4000_0001);
        model_smp = 14;
        rd(12'h04C, 32'd14, "R11");
        rd(12'h04C, 32'h0, "R11");

        // R4: run through the 12-bit wrap
        for (int i = 0; i < 600; i++) sample(1'b0, "R4");

        // R5: other resolutions
        wr(12'h004, 32'h0100_0000);
        for (int i = 0; i < 160; i++) sample(1'b0, "R5");
        wr(12'h004, 32'h0200_0000);
        for (int i = 0; i < 40; i++) sample(1'b0, "R5");
        wr(12'h004, 32'h0300_0000);
        for (int i = 0; i < 20; i++) sample(1'b0, "R5");

        // R6: left alignment at 12 and 8 bits
        wr(12'h004, 32'h0000_0000);
        for (int i = 0; i < 8; i++) sample(1'b1, "R6");
        wr(12'h004, 32'h0200_0000);
        for (int i = 0; i < 8; i++) sample(1'b1, "R6");
        wr(12'h004, 32'h0000_0000);

        // R7: top nibble of CR2 hidden
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, 32'h0FFF_FFFF, "R7");
        wr(12'h008, 32'h0);

        // R2: status bits cannot be set
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h0, "R2");

        // R8/R9: injected offsets and differences
        wr(12'h018, 32'hFFFF_F123);
        rd(12'h018, 32'h0000_0123, "R8");
        wr(12'h040, 32'h0000_0100);
        rd(12'h040, 32'hFFFF_FFDD, "R9");
        wr(12'h044, 32'hDEAD_BEEF);
        rd(12'h044, 32'hDEAD_BEEF, "R9");
        wr(12'h020, 32'h0000_0ABC);
        wr(12'h048, 32'h0000_1000);
        rd(12'h048, 32'h0000_0544, "R9");

        // R13: plain registers read back
        wr(12'h00C, 32'h1234_5678); rd(12'h00C, 32'h1234_5678, "R13");
        wr(12'h010, 32'h8765_4321); rd(12'h010, 32'h8765_4321, "R13");
        wr(12'h024, 32'hA5A5_0001); rd(12'h024, 32'hA5A5_0001, "R13");
        wr(12'h028, 32'h5A5A_0002); rd(12'h028, 32'h5A5A_0002, "R13");
        wr(12'h02C, 32'h0F0F_0F0F); rd(12'h02C, 32'h0F0F_0F0F, "R13");
        wr(12'h030, 32'hF0F0_F0F0); rd(12'h030, 32'hF0F0_F0F0, "R13");
        wr(12'h034, 32'h3333_CCCC); rd(12'h034, 32'h3333_CCCC, "R13");
        wr(12'h038, 32'hCAFE_F00D); rd(12'h038, 32'hCAFE_F00D, "R13");
        wr(12'h004, 32'h00AB_CDEF); rd(12'h004, 32'h00AB_CDEF, "R13");

        // R10: unmapped, misaligned, common area, regular-data write
        wr(12'h050, 32'hFFFF_FFFF);
        rd(12'h050, 32'h0, "R10");
        wr(12'h104, 32'h0300_0000);
        rd(12'h004, 32'h00AB_CDEF, "R10");
        rd(12'h104, 32'h0, "R10");
        rd(12'h005, 32'h0, "R10");
        wr(12'h04C, 32'h0000_0555);
        sample(1'b0, "R10");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule